// File: doc/BRIEF.md
# Quad DAC Serial Register Interface

This block is the digital control front end of a four-channel, 16-bit converter. A three-wire serial port (serial clock, active-low frame select and serial data) delivers 24-bit command frames. All three serial lines are brought into the system clock domain and their edges are detected there. A frame counts as valid only when exactly 24 falling serial-clock edges occur while the frame select is low. A valid frame is decoded when the frame select rises. The decoded frame either writes a 16-bit code into one channel's data register or into all four at once, or it requests a readback.

The data registers do not drive the converter directly. An active-low load input copies every data register into the output registers, and an active-low clear input forces every output register to zero code. Clear takes priority over load. After reset the outputs read zero and a clamp flag stays high until the first load or clear. The serial output either returns a requested readback word during the next frame or passes on the input bits delayed by one frame, which lets several devices share one chain.

Top module: `qdac_serial_ctrl`

## Requirements
- R1: After reset every output code is 0x0000, the clamp flag `out_clamped` is 1 and `ser_dout` is 0.
- R2: The frame is sent MSB first and bits are sampled on falling `ser_clk` edges while `ser_frame_n` is low. Bit 23 is the read flag (1 = read). Bit 22 is reserved and ignored. Bits 21:19 are the register select, bits 18:16 the channel address and bits 15:0 the data. A write frame with select 3'b010 and address 0..3 updates that channel's data register when `ser_frame_n` rises.
- R3: A frame with fewer than 24 falling `ser_clk` edges before `ser_frame_n` rises changes no register.
- R4: A frame with more than 24 falling `ser_clk` edges changes no register. The edge counter saturates and does not wrap.
- R5: Address 3'b100 writes all four channels. Addresses 3'b101 to 3'b111 are ignored, and so is any register select other than 3'b010.
- R6: While `load_n` is low, every output register takes its channel's data register value. Otherwise the outputs hold.
- R7: While `clear_n` is low, every output is 0x0000, even if `load_n` is also low. The data registers keep their contents.
- R8: `out_clamped` falls on the first load or clear after reset and never rises again until the next reset.
- R9: A valid read frame (bit 23 = 1, select 3'b010) loads the word {read flag, 0, select, address, register value} into the output shifter. The register value is 0 for an address above 3. The word appears on `ser_dout` MSB first during the next frame, and no register changes.
- R10: With no read pending, `ser_dout` presents the input bits delayed by 24 falling serial-clock edges (the previous frame, MSB first).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial clock; bits sampled on falling edges |
| ser_frame_n | input | 1 | Active-low frame select |
| ser_din | input | 1 | Serial data in, MSB first |
| load_n | input | 1 | Active-low load of all outputs from the data registers |
| clear_n | input | 1 | Active-low clear of all outputs to zero code |
| ser_dout | output | 1 | Readback or daisy-chain serial data out |
| chan_out | output | NUM_CH*DATA_W | Output codes; channel 0 in the low 16 bits |
| out_clamped | output | 1 | High from reset until the first load or clear |

## Verification
The hardest situation to reach from the ports is a readback. The register contents can only be observed on `ser_dout` during the frame that follows a read request, and that frame's own bits then take over the shifter. The stimulus sends a read frame and then an ignored frame, sampling `ser_dout` before every falling serial-clock edge. It then sends a third frame, whose output must repeat the ignored frame's bits. Short and long frames are checked by loading the outputs afterwards, which shows that no data register changed.

// File: rtl/qdac_pkg.sv
// Package: shared frame layout and code points of the quad DAC serial interface.
// Assumes a 24-bit frame: read flag, reserved bit, 3-bit select, 3-bit address, 16-bit data.
package qdac_pkg;
    localparam int FRAME_BITS = 24;
    localparam int DATA_BITS  = 16;
    localparam int FIELD_BITS = 3;

    localparam logic [FIELD_BITS-1:0] SEL_DAC  = 3'b010;
    localparam logic [FIELD_BITS-1:0] ADDR_ALL = 3'b100;

    typedef struct packed {
        logic                  rd;
        logic                  rsvd;
        logic [FIELD_BITS-1:0] sel;
        logic [FIELD_BITS-1:0] addr;
        logic [DATA_BITS-1:0]  data;
    } frame_t;
endpackage

// File: rtl/qdac_sync_edge.sv
// Module: multi-stage synchronizer with rising and falling edge detection.
// Assumes the input is asynchronous to clk; INIT is the idle level so reset gives no edge.
module qdac_sync_edge #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the asynchronous input through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{INIT}};
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    // Keep the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= INIT;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;
    assign fall  = ~level & prev;
endmodule

// File: rtl/qdac_frame_rx.sv
// Module: frame receiver; counts falling serial edges, shifts bits in, flags a valid frame.
// Assumes synchronized, edge-detected inputs; a frame is valid only with exactly FRAME_W edges.
module qdac_frame_rx #(
    parameter int FRAME_W = qdac_pkg::FRAME_BITS,
    parameter int CNT_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_fall,
    input  logic               sel_rise,
    input  logic               sel_lvl,
    input  logic               bit_edge,
    input  logic               bit_val,
    output logic               commit,
    output logic [FRAME_W-1:0] frame_q
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] CNT_GOOD = CNT_W'(FRAME_W);

    logic [CNT_W-1:0]   edge_cnt;
    logic [FRAME_W-1:0] shreg;
    logic               take_bit;

    assign take_bit = bit_edge & ~sel_lvl;

    // Count falling serial edges inside a frame, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)                             edge_cnt <= '0;
        else if (sel_fall)                      edge_cnt <= '0;
        else if (take_bit && edge_cnt != CNT_MAX) edge_cnt <= edge_cnt + 1'b1;
    end

    // Shift received bits in MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (take_bit) shreg <= {shreg[FRAME_W-2:0], bit_val};
    end

    // Raise a one-cycle commit when the frame ends with the exact edge count.
    always_ff @(posedge clk) begin
        if (!rst_n) commit <= 1'b0;
        else        commit <= sel_rise && (edge_cnt == CNT_GOOD);
    end

    assign frame_q = shreg;
endmodule

// File: rtl/qdac_chan_regs.sv
// Module: per-channel data registers, output registers, clamp flag and readback mux.
// Assumes single-cycle write strobes; clear has priority over load on the outputs.
module qdac_chan_regs
    import qdac_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = DATA_BITS,
    parameter int ADDR_W = FIELD_BITS
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_valid,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [FIELD_BITS-1:0]    wr_sel,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic                     load_act,
    input  logic                     clear_act,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [DATA_W-1:0]        rd_data,
    output logic [NUM_CH*DATA_W-1:0] dac_regs,
    output logic [NUM_CH*DATA_W-1:0] chan_out,
    output logic                     out_clamped
);
    logic sel_ok;
    assign sel_ok = wr_valid && (wr_sel == SEL_DAC);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic hit;
        assign hit = (wr_addr == ADDR_W'(ch)) || (wr_addr == ADDR_ALL);

        // Write the channel data register on an addressed valid frame.
        always_ff @(posedge clk) begin
            if (!rst_n)            dac_regs[ch*DATA_W +: DATA_W] <= '0;
            else if (sel_ok && hit) dac_regs[ch*DATA_W +: DATA_W] <= wr_data;
        end

        // Update the output register: clear first, then load, else hold.
        always_ff @(posedge clk) begin
            if (!rst_n)         chan_out[ch*DATA_W +: DATA_W] <= '0;
            else if (clear_act) chan_out[ch*DATA_W +: DATA_W] <= '0;
            else if (load_act)  chan_out[ch*DATA_W +: DATA_W] <= dac_regs[ch*DATA_W +: DATA_W];
        end
    end

    // Release the power-up clamp on the first load or clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                      out_clamped <= 1'b1;
        else if (load_act || clear_act)  out_clamped <= 1'b0;
    end

    // Select the addressed register for readback; unknown channels read zero.
    always_comb begin
        rd_data = '0;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            if (rd_addr == ADDR_W'(ch)) rd_data = dac_regs[ch*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/qdac_sdo_shift.sv
// Module: serial output shifter for readback and daisy-chain pass-through.
// Assumes load and shift never coincide; load wins if they do.
module qdac_sdo_shift #(
    parameter int FRAME_W = qdac_pkg::FRAME_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               shift_bit,
    input  logic               load_en,
    input  logic [FRAME_W-1:0] load_word,
    output logic               sdo
);
    logic [FRAME_W-1:0] shreg;

    // Load a readback word or shift in the incoming bit.
    always_ff @(posedge clk) begin
        if (!rst_n)        shreg <= '0;
        else if (load_en)  shreg <= load_word;
        else if (shift_en) shreg <= {shreg[FRAME_W-2:0], shift_bit};
    end

    assign sdo = shreg[FRAME_W-1];
endmodule

// File: rtl/qdac_serial_ctrl.sv
// Module: top of the quad DAC serial register interface.
// Assumes all serial and strobe inputs are asynchronous; they are synchronized here.
module qdac_serial_ctrl
    import qdac_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int DATA_W      = DATA_BITS,
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ser_clk,
    input  logic                     ser_frame_n,
    input  logic                     ser_din,
    input  logic                     load_n,
    input  logic                     clear_n,
    output logic                     ser_dout,
    output logic [NUM_CH*DATA_W-1:0] chan_out,
    output logic                     out_clamped
);
    localparam int        N_IN     = 5;
    localparam logic [N_IN-1:0] IDLE_LVL = 5'b11011;

    logic [N_IN-1:0] raw_in, lvl, rise, fall;
    logic            commit, load_act, clear_act, rd_go;
    logic [FRAME_BITS-1:0] frame_bits;
    frame_t          frm;
    logic [DATA_W-1:0] rd_data;
    logic [NUM_CH*DATA_W-1:0] dac_regs;
    logic [FRAME_BITS-1:0] rd_word;

    assign raw_in = {clear_n, load_n, ser_din, ser_frame_n, ser_clk};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        qdac_sync_edge #(.STAGES(SYNC_STAGES), .INIT(IDLE_LVL[i])) sync_i (
            .clk(clk), .rst_n(rst_n), .async_in(raw_in[i]),
            .level(lvl[i]), .rise(rise[i]), .fall(fall[i])
        );
    end

    assign load_act  = ~lvl[3];
    assign clear_act = ~lvl[4];

    qdac_frame_rx #(.FRAME_W(FRAME_BITS), .CNT_W(CNT_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .sel_fall(fall[1]), .sel_rise(rise[1]), .sel_lvl(lvl[1]),
        .bit_edge(fall[0]), .bit_val(lvl[2]),
        .commit(commit), .frame_q(frame_bits)
    );

    assign frm     = frame_t'(frame_bits);
    assign rd_go   = commit && frm.rd && (frm.sel == SEL_DAC);
    assign rd_word = {frm.rd, 1'b0, frm.sel, frm.addr, rd_data};

    qdac_chan_regs #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .ADDR_W(FIELD_BITS)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(commit && !frm.rd), .wr_addr(frm.addr), .wr_sel(frm.sel),
        .wr_data(frm.data), .load_act(load_act), .clear_act(clear_act),
        .rd_addr(frm.addr), .rd_data(rd_data),
        .dac_regs(dac_regs), .chan_out(chan_out), .out_clamped(out_clamped)
    );

    qdac_sdo_shift #(.FRAME_W(FRAME_BITS)) sdo_i (
        .clk(clk), .rst_n(rst_n),
        .shift_en(fall[0] & ~lvl[1]), .shift_bit(lvl[2]),
        .load_en(rd_go), .load_word(rd_word), .sdo(ser_dout)
    );
endmodule

// File: rtl/qdac_serial_ctrl_chk.sv
// Module: assertion checker for the quad DAC serial interface, bound to the top.
// Assumes it observes internal strobes of the top through the bind connections.
module qdac_serial_ctrl_chk #(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     commit,
    input logic [2:0]               wr_addr,
    input logic [NUM_CH*DATA_W-1:0] dac_regs,
    input logic [NUM_CH*DATA_W-1:0] chan_out,
    input logic                     load_act,
    input logic                     clear_act,
    input logic                     out_clamped
);
    p_regs_need_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(dac_regs));

    p_ignored_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && wr_addr > 3'd4) |=> $stable(dac_regs));

    p_out_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_act && !clear_act) |=> $stable(chan_out));

    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear_act |=> (chan_out == '0));

    p_clamp_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_clamped) |-> $past(load_act || clear_act));

    p_clamp_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !out_clamped |=> !out_clamped);
endmodule

bind qdac_serial_ctrl qdac_serial_ctrl_chk #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .wr_addr(frm.addr),
    .dac_regs(dac_regs), .chan_out(chan_out), .load_act(load_act),
    .clear_act(clear_act), .out_clamped(out_clamped)
);

// File: tb/qdac_serial_ctrl_tb.sv
module qdac_serial_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_clk = 1'b1, ser_frame_n = 1'b1, ser_din = 1'b0;
    logic        load_n = 1'b1, clear_n = 1'b1;
    logic        ser_dout, out_clamped;
    logic [63:0] chan_out;
    logic [23:0] sdo_cap;
    int          checks = 0, fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    qdac_serial_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_frame_n(ser_frame_n),
        .ser_din(ser_din), .load_n(load_n), .clear_n(clear_n),
        .ser_dout(ser_dout), .chan_out(chan_out), .out_clamped(out_clamped)
    );

    // Entry: {frame word, falling edge count, expected outputs after load}
    localparam int NV = 9;
    localparam logic [93:0] VEC [NV] = '{
        {24'h10_1234, 6'd24, 64'h0000_0000_0000_1234},  // R2 ch0
        {24'h12_BEEF, 6'd24, 64'h0000_BEEF_0000_1234},  // R2 ch2
        {24'h11_5555, 6'd23, 64'h0000_BEEF_0000_1234},  // R3 short
        {24'h13_7777, 6'd25, 64'h0000_BEEF_0000_1234},  // R4 long
        {24'h14_0A0A, 6'd24, 64'h0A0A_0A0A_0A0A_0A0A},  // R5 all
        {24'h15_FFFF, 6'd24, 64'h0A0A_0A0A_0A0A_0A0A},  // R5 addr 5
        {24'h19_1111, 6'd24, 64'h0A0A_0A0A_0A0A_0A0A},  // R5 sel 011
        {24'h13_C3C3, 6'd24, 64'hC3C3_0A0A_0A0A_0A0A},  // R2 ch3
        {24'h51_8001, 6'd24, 64'hC3C3_0A0A_8001_0A0A}   // R2 reserved bit set
    };
    localparam string VREQ [NV] = '{"R2", "R2", "R3", "R4", "R5", "R5", "R5", "R2", "R2"};

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Send one frame of n falling edges, capturing ser_dout before each edge.
    task automatic send(input logic [23:0] w, input int n);
        sdo_cap = '0;
        ser_frame_n = 1'b0;
        wclk(4);
        for (int i = 0; i < n; i++) begin
            ser_din = (i < 24) ? w[23-i] : 1'b0;
            wclk(4);
            if (i < 24) sdo_cap[23-i] = ser_dout;
            ser_clk = 1'b0;
            wclk(4);
            ser_clk = 1'b1;
        end
        wclk(4);
        ser_frame_n = 1'b1;
        wclk(10);
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wclk(4);
        load_n = 1'b1;
        wclk(6);
    endtask

    initial begin
        logic [63:0] prev = '0;
        wclk(5);
        rst_n = 1'b1;
        wclk(3);
        check("R1", chan_out, 64'h0);
        check("R1", {63'h0, ser_dout}, 64'h0);
        check("R8", {63'h0, out_clamped}, 64'h1);

        for (int k = 0; k < NV; k++) begin
            send(VEC[k][93:70], int'(VEC[k][69:64]));
            check("R6", chan_out, prev);  // outputs hold until load
            if (k == 0) check("R8", {63'h0, out_clamped}, 64'h1);
            pulse_load();
            check(VREQ[k], chan_out, VEC[k][63:0]);
            prev = VEC[k][63:0];
        end
        check("R8", {63'h0, out_clamped}, 64'h0);

        // R7: clear forces zero, wins over load, keeps data registers
        clear_n = 1'b0;
        wclk(6);
        check("R7", chan_out, 64'h0);
        load_n = 1'b0;
        wclk(6);
        check("R7", chan_out, 64'h0);
        clear_n = 1'b1;
        wclk(6);
        check("R7", chan_out, 64'hC3C3_0A0A_8001_0A0A);
        load_n = 1'b1;
        wclk(6);
        check("R8", {63'h0, out_clamped}, 64'h0);

        // R9: read channel 2, shift it out on the next frame
        send(24'h92_0000, 24);
        send(24'h18_0000, 24);
        check("R9", {40'h0, sdo_cap}, {40'h0, 24'h92_0A0A});
        pulse_load();
        check("R9", chan_out, 64'hC3C3_0A0A_8001_0A0A);

        // R9: read address 6 returns zero data
        send(24'h96_0000, 24);
        send(24'h19_ABCD, 24);
        check("R9", {40'h0, sdo_cap}, {40'h0, 24'h96_0000});

        // R10: daisy chain, previous frame bits appear
        send(24'h1D_1357, 24);
        check("R10", {40'h0, sdo_cap}, {40'h0, 24'h19_ABCD});
        send(24'h18_0000, 24);
        check("R10", {40'h0, sdo_cap}, {40'h0, 24'h1D_1357});

        // R1: reset again restores power-up state
        rst_n = 1'b0;
        wclk(3);
        rst_n = 1'b1;
        wclk(3);
        check("R1", chan_out, 64'h0);
        check("R1", {63'h0, out_clamped}, 64'h1);
        pulse_load();
        check("R1", chan_out, 64'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule